// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches translation entries for a 32-bit virtual address space with 4 KB pages. It holds 64 entries arranged as 16 sets of 4 ways. Each entry stores either a page-directory entry or a page-table entry, with a one-bit kind flag that records which one it is. A lookup presents a 20-bit virtual page number, the wanted kind and the 12-bit page offset. One cycle later the block answers hit or miss. On a hit it also returns the cached 32-bit entry and the assembled physical address.

On a miss, the surrounding walker fetches the table entry from memory, and the directory entry too if that is not cached. It then installs each fetched entry through the fill port. The block chooses the way for each fill itself. Two flush inputs serve address-space changes. The task-switch flush keeps entries marked global. The full flush clears every entry.

Top module: `vpn_tlb`

## Requirements
- R1: While reset is asserted, res_valid, res_hit, res_pte and res_paddr are all 0. After reset every entry is invalid, so every lookup misses.
- R2: The set index is vpn[3:0] and the tag is vpn[19:4]. A lookup hits only on a valid way of the indexed set whose tag matches and whose kind flag equals lk_kind_dir (1 = directory entry, 0 = table entry).
- R3: The result is registered. In the cycle after a lookup is presented, res_valid is 1, and it is 0 after a cycle with no lookup. A lookup sees the contents as they were before any fill or flush presented in the same cycle.
- R4: On a hit, res_pte is the stored entry and res_paddr is {res_pte[31:12], lk_offset}. On a miss, both are 0.
- R5: A fill whose tag and kind are not already present in the set writes the lowest-numbered invalid way of that set.
- R6: When the set is full, a fill evicts the way named by that set's round-robin pointer. The pointer starts at way 0 and steps by one, wrapping from 3 to 0, only on such an eviction.
- R7: A fill whose tag and kind already sit in a valid way overwrites that way in place and evicts nothing. No two valid ways of a set ever match the same tag and kind.
- R8: flush_task invalidates every entry whose bit 8 (global) is 0 and keeps every entry whose bit 8 is 1.
- R9: flush_all invalidates every entry, global ones included.
- R10: A fill presented in the same cycle as either flush is applied after the flush, so the filled entry is valid afterwards.
- R11: A directory entry and a table entry with the same page number are held as two separate entries, and each is found only by a lookup of its own kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_kind_dir | input | 1 | Wanted kind: 1 directory entry, 0 table entry |
| lk_offset | input | 12 | Page offset, passed into the physical address |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | 20 | Page number of the entry to install |
| fill_kind_dir | input | 1 | Kind of the entry to install |
| fill_pte | input | 32 | Entry contents; bit 8 is the global mark |
| flush_task | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Result present (one cycle after lk_valid) |
| res_hit | output | 1 | Lookup hit |
| res_pte | output | 32 | Cached entry on hit, else 0 |
| res_paddr | output | 32 | Frame number joined with offset on hit, else 0 |

## Verification
A corrupted valid bit, tag or kind flag inside the array is invisible until a lookup reaches that set. It then shows as a wrong res_hit or wrong res_pte exactly one cycle after that lookup. A wrong round-robin pointer or free-way choice shows no error at fill time. It appears only when a later fill evicts a different entry than expected, so the bench fills sets past capacity and probes every resident tag afterwards. A flush that spares or kills the wrong entries is caught by the first lookup of an affected page after the flush.

// File: rtl/vpn_tlb_pkg.sv
package vpn_tlb_pkg;
  localparam int TLB_SETS    = 16;
  localparam int TLB_WAYS    = 4;
  localparam int TLB_VPN_W   = 20;
  localparam int TLB_OFS_W   = 12;
  localparam int TLB_PTE_W   = 32;
  localparam int TLB_GLB_BIT = 8;

  // Physical address: frame number from the entry, offset passed through.
  function automatic logic [TLB_PTE_W-1:0] tlb_join_paddr(
    input logic [TLB_PTE_W-1:0] pte,
    input logic [TLB_OFS_W-1:0] ofs
  );
    return {pte[TLB_PTE_W-1:TLB_OFS_W], ofs};
  endfunction
endpackage

// File: rtl/vpn_tlb_store.sv
module vpn_tlb_store #(
  parameter int SETS    = 16,
  parameter int WAYS    = 4,
  parameter int IDX_W   = 4,
  parameter int WAY_W   = 2,
  parameter int TAG_W   = 16,
  parameter int PTE_W   = 32,
  parameter int GLB_BIT = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush_task,
  input  logic                             flush_all,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [WAY_W-1:0]                 wr_way,
  input  logic                             wr_dir,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [PTE_W-1:0]                 wr_pte,
  input  logic [IDX_W-1:0]                 ra_idx,
  input  logic [IDX_W-1:0]                 rb_idx,
  output logic [WAYS-1:0]                  ra_vld,
  output logic [WAYS-1:0]                  ra_dir,
  output logic [WAYS-1:0][TAG_W-1:0]       ra_tag,
  output logic [WAYS-1:0][PTE_W-1:0]       ra_pte,
  output logic [WAYS-1:0]                  rb_vld,
  output logic [WAYS-1:0]                  rb_dir,
  output logic [WAYS-1:0][TAG_W-1:0]       rb_tag
);
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0]             dir_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][PTE_W-1:0]  pte_q [SETS];

  // Valid bits: flush first, then the fill sets its way.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (flush_all || (flush_task && !pte_q[s][w][GLB_BIT]))
            vld_q[s][w] <= 1'b0;
        end
      end
      if (wr_en) vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  // Payload needs no reset; valid bits gate it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      dir_q[wr_idx][wr_way] <= wr_dir;
      tag_q[wr_idx][wr_way] <= wr_tag;
      pte_q[wr_idx][wr_way] <= wr_pte;
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign ra_dir = dir_q[ra_idx];
  assign ra_tag = tag_q[ra_idx];
  assign ra_pte = pte_q[ra_idx];
  assign rb_vld = vld_q[rb_idx];
  assign rb_dir = dir_q[rb_idx];
  assign rb_tag = tag_q[rb_idx];
endmodule

// File: rtl/vpn_tlb_cmp.sv
module vpn_tlb_cmp #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            dir,
  input  logic [WAYS-1:0][TAG_W-1:0] tag,
  input  logic [TAG_W-1:0]           key_tag,
  input  logic                       key_dir,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = vld[w] && (dir[w] == key_dir) && (tag[w] == key_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vpn_tlb_repl.sv
module vpn_tlb_repl #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAYS-1:0]  set_vld,
  input  logic             match_hit,
  input  logic [WAY_W-1:0] match_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             take_ptr
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  // Lowest-numbered invalid way wins.
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_vld[w]) free_way = WAY_W'(w);
    end
  end

  assign any_free   = ~&set_vld;
  assign take_ptr   = !match_hit && !any_free;
  assign victim_way = match_hit ? match_way :
                      any_free  ? free_way  : ptr_q[fill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (fill_en && take_ptr) begin
      ptr_q[fill_idx] <= (ptr_q[fill_idx] == WAY_W'(WAYS - 1)) ? '0
                                                             : ptr_q[fill_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/vpn_tlb.sv
module vpn_tlb
  import vpn_tlb_pkg::*;
#(
  parameter int SETS    = TLB_SETS,
  parameter int WAYS    = TLB_WAYS,
  parameter int VPN_W   = TLB_VPN_W,
  parameter int OFS_W   = TLB_OFS_W,
  parameter int PTE_W   = TLB_PTE_W,
  parameter int GLB_BIT = TLB_GLB_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_kind_dir,
  input  logic [OFS_W-1:0] lk_offset,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_kind_dir,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             flush_task,
  input  logic             flush_all,
  output logic             res_valid,
  output logic             res_hit,
  output logic [PTE_W-1:0] res_pte,
  output logic [PTE_W-1:0] res_paddr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]            ra_vld, ra_dir, rb_vld, rb_dir;
  logic [WAYS-1:0][TAG_W-1:0] ra_tag, rb_tag;
  logic [WAYS-1:0][PTE_W-1:0] ra_pte;

  // Named internal events, observed by the bound checker.
  logic [WAYS-1:0]  lk_hit_vec, fill_hit_vec;
  logic             lk_hit, fill_hit, fill_take_ptr;
  logic [WAY_W-1:0] lk_way, fill_match_way, fill_way;
  logic [PTE_W-1:0] lk_sel_pte;

  vpn_tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W),
    .TAG_W(TAG_W), .PTE_W(PTE_W), .GLB_BIT(GLB_BIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .flush_task(flush_task), .flush_all(flush_all),
    .wr_en(fill_valid), .wr_idx(fill_idx), .wr_way(fill_way),
    .wr_dir(fill_kind_dir), .wr_tag(fill_tag), .wr_pte(fill_pte),
    .ra_idx(lk_idx), .rb_idx(fill_idx),
    .ra_vld(ra_vld), .ra_dir(ra_dir), .ra_tag(ra_tag), .ra_pte(ra_pte),
    .rb_vld(rb_vld), .rb_dir(rb_dir), .rb_tag(rb_tag)
  );

  vpn_tlb_cmp #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_lk_cmp (
    .vld(ra_vld), .dir(ra_dir), .tag(ra_tag),
    .key_tag(lk_tag), .key_dir(lk_kind_dir),
    .hit_vec(lk_hit_vec), .hit(lk_hit), .hit_way(lk_way)
  );

  vpn_tlb_cmp #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_fill_cmp (
    .vld(rb_vld), .dir(rb_dir), .tag(rb_tag),
    .key_tag(fill_tag), .key_dir(fill_kind_dir),
    .hit_vec(fill_hit_vec), .hit(fill_hit), .hit_way(fill_match_way)
  );

  vpn_tlb_repl #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_repl (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_valid), .fill_idx(fill_idx), .set_vld(rb_vld),
    .match_hit(fill_hit), .match_way(fill_match_way),
    .victim_way(fill_way), .take_ptr(fill_take_ptr)
  );

  assign lk_sel_pte = ra_pte[lk_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pte   <= '0;
      res_paddr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && lk_hit;
      res_pte   <= (lk_valid && lk_hit) ? lk_sel_pte : '0;
      res_paddr <= (lk_valid && lk_hit) ? tlb_join_paddr(lk_sel_pte, lk_offset) : '0;
    end
  end
endmodule

// File: rtl/vpn_tlb_chk.sv
module vpn_tlb_chk #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int OFS_W = 12,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [OFS_W-1:0] lk_offset,
  input logic             fill_valid,
  input logic             flush_all,
  input logic             res_valid,
  input logic             res_hit,
  input logic [PTE_W-1:0] res_pte,
  input logic [PTE_W-1:0] res_paddr,
  input logic [WAYS-1:0]  lk_hit_vec,
  input logic [WAYS-1:0]  fill_hit_vec,
  input logic [WAYS-1:0]  fill_set_vld,
  input logic             fill_hit,
  input logic [WAY_W-1:0] fill_way,
  input logic             fill_take_ptr
);
  // R3
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R3
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit));

  // R4
  paddr_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_paddr[OFS_W-1:0] == $past(lk_offset) &&
                 res_paddr[PTE_W-1:OFS_W] == res_pte[PTE_W-1:OFS_W]));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_pte == '0 && res_paddr == '0));

  // R7
  lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  // R7
  fill_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit_vec));

  // R7
  refill_in_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_hit) |-> fill_hit_vec[fill_way]);

  // R5
  fill_free_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_hit && !(&fill_set_vld)) |-> !fill_set_vld[fill_way]);

  // R6
  full_set_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_hit && (&fill_set_vld)) |-> fill_take_ptr);

  // R9
  flush_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_all) && !$past(fill_valid) && lk_valid) |=> !res_hit);
endmodule

bind vpn_tlb vpn_tlb_chk #(
  .WAYS(WAYS), .WAY_W(WAY_W), .OFS_W(OFS_W), .PTE_W(PTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_offset(lk_offset),
  .fill_valid(fill_valid), .flush_all(flush_all),
  .res_valid(res_valid), .res_hit(res_hit),
  .res_pte(res_pte), .res_paddr(res_paddr),
  .lk_hit_vec(lk_hit_vec), .fill_hit_vec(fill_hit_vec),
  .fill_set_vld(rb_vld), .fill_hit(fill_hit),
  .fill_way(fill_way), .fill_take_ptr(fill_take_ptr)
);

// File: tb/vpn_tlb_bench.sv
module vpn_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_kind_dir, fill_valid, fill_kind_dir;
  logic        flush_task, flush_all;
  logic [19:0] lk_vpn, fill_vpn;
  logic [11:0] lk_offset;
  logic [31:0] fill_pte;
  logic        res_valid, res_hit;
  logic [31:0] res_pte, res_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vpn_tlb u_vpn_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind_dir(lk_kind_dir), .lk_offset(lk_offset),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_kind_dir(fill_kind_dir),
    .fill_pte(fill_pte), .flush_task(flush_task), .flush_all(flush_all),
    .res_valid(res_valid), .res_hit(res_hit), .res_pte(res_pte), .res_paddr(res_paddr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mkv(input logic [15:0] tag, input logic [3:0] set);
    return {tag, set};
  endfunction

  // Non-global entry (bit 8 = 0) and global entry (bit 8 = 1), frame = {0, tag}.
  function automatic logic [31:0] ng(input logic [15:0] tag);
    return {4'h0, tag, 12'h007};
  endfunction
  function automatic logic [31:0] gl(input logic [15:0] tag);
    return {4'h0, tag, 12'h107};
  endfunction

  task automatic fill(input logic [19:0] vpn, input logic dir, input logic [31:0] pte);
    fill_valid = 1'b1; fill_vpn = vpn; fill_kind_dir = dir; fill_pte = pte;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic check_res(input string req, input logic [11:0] ofs,
                           input bit exp_hit, input logic [31:0] exp_pte);
    logic [31:0] ep, ea;
    ep = exp_hit ? exp_pte : 32'h0;
    ea = exp_hit ? {exp_pte[31:12], ofs} : 32'h0;
    chk(res_valid === 1'b1, req, "res_valid", 32'(res_valid), 32'd1);
    chk(res_hit === exp_hit, req, "res_hit", 32'(res_hit), 32'(exp_hit));
    chk(res_pte === ep, req, "res_pte", res_pte, ep);
    chk(res_paddr === ea, req, "res_paddr", res_paddr, ea);
  endtask

  task automatic look(input logic [19:0] vpn, input logic dir, input logic [11:0] ofs,
                      input bit exp_hit, input logic [31:0] exp_pte, input string req);
    lk_valid = 1'b1; lk_vpn = vpn; lk_kind_dir = dir; lk_offset = ofs;
    @(negedge clk);
    check_res(req, ofs, exp_hit, exp_pte);
    lk_valid = 1'b0;
  endtask

  // R1: reset values and empty array
  task automatic t_reset();
    chk(res_valid === 1'b0, "R1", "res_valid", 32'(res_valid), 0);
    chk(res_hit === 1'b0, "R1", "res_hit", 32'(res_hit), 0);
    chk(res_pte === 32'h0, "R1", "res_pte", res_pte, 0);
    chk(res_paddr === 32'h0, "R1", "res_paddr", res_paddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    look(mkv(16'h0000, 4'h0), 1'b0, 12'h000, 1'b0, 0, "R1");
  endtask

  // R2, R4: index/tag/kind matching and address assembly
  task automatic t_basic();
    fill(mkv(16'h1234, 4'h1), 1'b0, 32'hABCDE007);
    look(mkv(16'h1234, 4'h1), 1'b0, 12'h5A5, 1'b1, 32'hABCDE007, "R4");
    look(mkv(16'h1234, 4'h1), 1'b0, 12'hFFF, 1'b1, 32'hABCDE007, "R4");
    look(mkv(16'h1235, 4'h1), 1'b0, 12'h5A5, 1'b0, 0, "R2");
    look(mkv(16'h1234, 4'h1), 1'b1, 12'h5A5, 1'b0, 0, "R2");
    look(mkv(16'h1234, 4'h2), 1'b0, 12'h5A5, 1'b0, 0, "R2");
  endtask

  // R11: directory and table entries for one page coexist
  task automatic t_kinds();
    fill(mkv(16'h1234, 4'h1), 1'b1, 32'h11111003);
    look(mkv(16'h1234, 4'h1), 1'b0, 12'h010, 1'b1, 32'hABCDE007, "R11");
    look(mkv(16'h1234, 4'h1), 1'b1, 12'h020, 1'b1, 32'h11111003, "R11");
  endtask

  // R5, R6: free ways first, then round-robin eviction with wrap
  task automatic t_rr();
    for (int i = 0; i < 4; i++) fill(mkv(16'hA000 + 16'(i), 4'h3), 1'b0, ng(16'hA000 + 16'(i)));
    for (int i = 0; i < 4; i++) look(mkv(16'hA000 + 16'(i), 4'h3), 1'b0, 12'h0, 1'b1, ng(16'hA000 + 16'(i)), "R5");
    fill(mkv(16'hA004, 4'h3), 1'b0, ng(16'hA004));
    look(mkv(16'hA000, 4'h3), 1'b0, 12'h0, 1'b0, 0, "R6");
    for (int i = 1; i < 5; i++) look(mkv(16'hA000 + 16'(i), 4'h3), 1'b0, 12'h0, 1'b1, ng(16'hA000 + 16'(i)), "R6");
    fill(mkv(16'hA005, 4'h3), 1'b0, ng(16'hA005));
    look(mkv(16'hA001, 4'h3), 1'b0, 12'h0, 1'b0, 0, "R6");
    look(mkv(16'hA002, 4'h3), 1'b0, 12'h0, 1'b1, ng(16'hA002), "R6");
    fill(mkv(16'hA006, 4'h3), 1'b0, ng(16'hA006));
    fill(mkv(16'hA007, 4'h3), 1'b0, ng(16'hA007));
    fill(mkv(16'hA008, 4'h3), 1'b0, ng(16'hA008));
    look(mkv(16'hA004, 4'h3), 1'b0, 12'h0, 1'b0, 0, "R6");
    look(mkv(16'hA008, 4'h3), 1'b0, 12'h0, 1'b1, ng(16'hA008), "R6");
    look(mkv(16'hA005, 4'h3), 1'b0, 12'h0, 1'b1, ng(16'hA005), "R6");
  endtask

  // R7: refill of a resident key updates in place
  task automatic t_refill();
    for (int i = 0; i < 4; i++) fill(mkv(16'hB000 + 16'(i), 4'h5), 1'b0, ng(16'hB000 + 16'(i)));
    fill(mkv(16'hB001, 4'h5), 1'b0, 32'h7777_7007);
    look(mkv(16'hB000, 4'h5), 1'b0, 12'h1, 1'b1, ng(16'hB000), "R7");
    look(mkv(16'hB001, 4'h5), 1'b0, 12'h1, 1'b1, 32'h7777_7007, "R7");
    fill(mkv(16'hB004, 4'h5), 1'b0, ng(16'hB004));
    look(mkv(16'hB000, 4'h5), 1'b0, 12'h1, 1'b0, 0, "R7");
    look(mkv(16'hB001, 4'h5), 1'b0, 12'h1, 1'b1, 32'h7777_7007, "R7");
    look(mkv(16'hB004, 4'h5), 1'b0, 12'h1, 1'b1, ng(16'hB004), "R7");
  endtask

  // R8: task flush keeps global entries; freed ways are reused first (R5)
  task automatic t_flush_task();
    fill(mkv(16'hC000, 4'h7), 1'b0, ng(16'hC000));
    fill(mkv(16'hC001, 4'h7), 1'b0, gl(16'hC001));
    fill(mkv(16'hC002, 4'h7), 1'b0, ng(16'hC002));
    fill(mkv(16'hC003, 4'h7), 1'b0, gl(16'hC003));
    flush_task = 1'b1;
    @(negedge clk);
    flush_task = 1'b0;
    look(mkv(16'hC000, 4'h7), 1'b0, 12'h2, 1'b0, 0, "R8");
    look(mkv(16'hC001, 4'h7), 1'b0, 12'h2, 1'b1, gl(16'hC001), "R8");
    look(mkv(16'hC002, 4'h7), 1'b0, 12'h2, 1'b0, 0, "R8");
    look(mkv(16'hC003, 4'h7), 1'b0, 12'h2, 1'b1, gl(16'hC003), "R8");
    fill(mkv(16'hC010, 4'h7), 1'b0, ng(16'hC010));
    fill(mkv(16'hC011, 4'h7), 1'b0, ng(16'hC011));
    fill(mkv(16'hC012, 4'h7), 1'b0, ng(16'hC012));
    look(mkv(16'hC010, 4'h7), 1'b0, 12'h3, 1'b0, 0, "R5");
    look(mkv(16'hC011, 4'h7), 1'b0, 12'h3, 1'b1, ng(16'hC011), "R5");
    look(mkv(16'hC012, 4'h7), 1'b0, 12'h3, 1'b1, ng(16'hC012), "R6");
    look(mkv(16'hC001, 4'h7), 1'b0, 12'h3, 1'b1, gl(16'hC001), "R8");
  endtask

  // R9: full flush clears global entries too
  task automatic t_flush_all();
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    look(mkv(16'hC001, 4'h7), 1'b0, 12'h4, 1'b0, 0, "R9");
    look(mkv(16'hC003, 4'h7), 1'b0, 12'h4, 1'b0, 0, "R9");
    look(mkv(16'h1234, 4'h1), 1'b1, 12'h4, 1'b0, 0, "R9");
  endtask

  // R10: fill in the same cycle as a flush survives it
  task automatic t_flush_fill();
    flush_all = 1'b1;
    fill(mkv(16'hE000, 4'h9), 1'b0, ng(16'hE000));
    flush_all = 1'b0;
    look(mkv(16'hE000, 4'h9), 1'b0, 12'h5, 1'b1, ng(16'hE000), "R10");
    flush_task = 1'b1;
    fill(mkv(16'hE001, 4'h9), 1'b1, ng(16'hE001));
    flush_task = 1'b0;
    look(mkv(16'hE001, 4'h9), 1'b1, 12'h6, 1'b1, ng(16'hE001), "R10");
    look(mkv(16'hE000, 4'h9), 1'b0, 12'h6, 1'b0, 0, "R8");
  endtask

  // R3: lookup sees pre-fill contents; idle cycle drops res_valid
  task automatic t_timing();
    lk_valid = 1'b1; lk_vpn = mkv(16'hD000, 4'hA); lk_kind_dir = 1'b0; lk_offset = 12'h7;
    fill_valid = 1'b1; fill_vpn = mkv(16'hD000, 4'hA); fill_kind_dir = 1'b0; fill_pte = ng(16'hD000);
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    check_res("R3", 12'h7, 1'b0, 0);
    look(mkv(16'hD000, 4'hA), 1'b0, 12'h8, 1'b1, ng(16'hD000), "R3");
    @(negedge clk);
    chk(res_valid === 1'b0, "R3", "res_valid idle", 32'(res_valid), 0);
    chk(res_hit === 1'b0, "R3", "res_hit idle", 32'(res_hit), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_vpn = '0; lk_kind_dir = 1'b0; lk_offset = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_kind_dir = 1'b0; fill_pte = '0;
    flush_task = 1'b0; flush_all = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_kinds();
    t_rr();
    t_refill();
    t_flush_task();
    t_flush_all();
    t_flush_fill();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule